// File: doc/BRIEF.md
# Serial Port Status and Interrupt Unit

This block holds the flag, error, mask and control state of a byte-wide serial port, and turns that state into a single interrupt request. Software reaches it through a small 16-bit register bus with one-cycle registered read data. The transmit shifter and the receive shifter connect through event inputs. The transmit shifter reports when it has taken the buffered byte and when it has finished shifting. The receive shifter presents each received byte together with its parity and framing verdicts.

Transmission counts as finished only when the buffer-empty flag and the shift-empty flag are both set. Reading the receive data register frees the receive buffer and wipes every pending receive error. If a byte arrives while the buffer is still occupied, the block flags an overrun and keeps the older byte. A summary error flag is the OR of the three individual receive errors. A separate error view repeats the four error flags in the same bit positions. Writing zero to that view clears the errors without reading the data.

Register word addresses are: 0 control, 1 status (read only), 2 error view, 3 interrupt mask, 4 transmit data (write loads, read returns the buffered byte), 5 receive data (read only, read has side effects). Unused bits read as zero.

Top module: `sio_status_irq`

## Requirements
- R1: After reset the status register reads 0x0003 (both transmit-empty flags set). Control, mask and the error view read 0, and the irq, tx_enable, rx_enable and tx_flush outputs are low.
- R2: Control bit 0 drives tx_enable and bit 1 drives rx_enable, and both read back. Writing 1 to control bit 2 raises tx_flush for one cycle, then sets transmit-buffer-empty (status bit 0). Control bit 2 always reads 0.
- R3: Writing the transmit data register loads tx_byte_o, sets tx_full and clears status bit 0. A txs_taken pulse sets bit 0 and clears transmit-shift-empty (status bit 1). A txs_done pulse sets bit 1. Transmission is complete only when bits 0 and 1 are both 1.
- R4: While rx_enable is high, an rxs_valid pulse stores rxs_byte and sets receive-full (status bit 2). While rx_enable is low, rxs_valid is ignored.
- R5: The parity and framing verdicts that come with an accepted byte are stored in status bits 3 and 4.
- R6: A byte that arrives while status bit 2 is still set sets overrun (status bit 5). The stored byte stays unchanged.
- R7: Status bit 6 (sum error) is set exactly when any of bits 3, 4 or 5 is set.
- R8: Reading the receive data register returns the stored byte. It also clears status bits 2, 3, 4, 5 and 6.
- R9: The error view returns status bits 3 to 6 in place, with all other bits zero. Writing 0x0000 to it clears all four. A nonzero write to it is ignored.
- R10: The mask register stores only bits 0, 1, 2 and 6. All other mask bits read 0.
- R11: irq is the OR of each status flag (bits 0, 1, 2, 6) ANDed with its mask bit, delayed by one register. irq rises one cycle after the flag and mask line up, and falls one cycle after they stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| txs_taken | input | 1 | Transmit shifter took the buffered byte |
| txs_done | input | 1 | Transmit shifter finished shifting |
| tx_byte_o | output | BYTE_W | Byte waiting in the transmit buffer |
| tx_full | output | 1 | Transmit buffer holds a byte |
| tx_enable | output | 1 | Transmit enable |
| rx_enable | output | 1 | Receive enable |
| tx_flush | output | 1 | One-cycle transmit data clear pulse |
| rxs_valid | input | 1 | Receive shifter has a byte |
| rxs_byte | input | BYTE_W | Received byte |
| rxs_parity_err | input | 1 | Parity verdict for the byte |
| rxs_frame_err | input | 1 | Framing verdict for the byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after the overrun case. A design that overwrites the buffered byte would return the newer byte on the next data read, and one that drops the flag would show 0x57 instead of 0x77 in status. It also checks that a nonzero write to the error view leaves the errors standing. A design that clears on any write would read the error view as zero too early. The one-cycle irq delay is sampled on both edges, so a combinational or two-stage irq shows up as a mismatch. A receive byte sent while receive is disabled must leave status at 0x0003, which exposes a design that ignores rx_enable.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // register word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_ERRV = 2;
  localparam int unsigned A_MASK = 3;
  localparam int unsigned A_TXD  = 4;
  localparam int unsigned A_RXD  = 5;
  // status / mask bit positions
  localparam int unsigned ST_TBE  = 0;
  localparam int unsigned ST_TSBE = 1;
  localparam int unsigned ST_RBF  = 2;
  localparam int unsigned ST_PAR  = 3;
  localparam int unsigned ST_FRM  = 4;
  localparam int unsigned ST_OVR  = 5;
  localparam int unsigned ST_SUM  = 6;
  // control bit positions
  localparam int unsigned CT_TXEN = 0;
  localparam int unsigned CT_RXEN = 1;
  localparam int unsigned CT_FLSH = 2;
  localparam int unsigned CT_W    = 3;
endpackage

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs import sio_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CT_W-1:0]   ctrl_wdata,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] mask_wdata,
  output logic              tx_en,
  output logic              rx_en,
  output logic              flush,
  output logic [DATA_W-1:0] mask_q
);
  localparam logic [DATA_W-1:0] MASK_KEEP =
    (DATA_W'(1) << ST_TBE) | (DATA_W'(1) << ST_TSBE) |
    (DATA_W'(1) << ST_RBF) | (DATA_W'(1) << ST_SUM);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      flush  <= 1'b0;
      mask_q <= '0;
    end else begin
      flush <= wr_ctrl & ctrl_wdata[CT_FLSH];
      if (wr_ctrl) begin
        tx_en <= ctrl_wdata[CT_TXEN];
        rx_en <= ctrl_wdata[CT_RXEN];
      end
      if (wr_mask) mask_q <= mask_wdata & MASK_KEEP;
    end
  end
endmodule

// File: rtl/sio_tx_flags.sv
module sio_tx_flags #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_txd,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              flush,
  input  logic              taken,
  input  logic              done,
  output logic              tbe,
  output logic              tsbe,
  output logic [BYTE_W-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tbe     <= 1'b1;
      tsbe    <= 1'b1;
      tx_byte <= '0;
    end else begin
      if (flush)       tbe <= 1'b1;
      else if (wr_txd) tbe <= 1'b0;
      else if (taken)  tbe <= 1'b1;
      if (wr_txd) tx_byte <= wbyte;
      if (taken)      tsbe <= 1'b0;
      else if (done)  tsbe <= 1'b1;
    end
  end

  p_taken_empties_r3: assert property (@(posedge clk) disable iff (rst)
    (taken && !wr_txd && !flush) |=> (tbe && !tsbe));
  p_load_fills_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_txd && !flush) |=> (!tbe && tx_byte == $past(wbyte)));
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              valid,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              par_in,
  input  logic              frm_in,
  input  logic              drain,
  input  logic              err_clr,
  output logic              rbf,
  output logic              par,
  output logic              frm,
  output logic              ovr,
  output logic [BYTE_W-1:0] rx_byte
);
  logic take;
  assign take = valid & rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbf     <= 1'b0;
      par     <= 1'b0;
      frm     <= 1'b0;
      ovr     <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (drain) begin
        rbf <= 1'b0;
        par <= 1'b0;
        frm <= 1'b0;
        ovr <= 1'b0;
      end
      if (err_clr) begin
        par <= 1'b0;
        frm <= 1'b0;
        ovr <= 1'b0;
      end
      if (take) begin
        if (!rbf || drain) begin
          rx_byte <= byte_in;
          rbf     <= 1'b1;
          par     <= par_in;
          frm     <= frm_in;
          ovr     <= 1'b0;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end

  p_overrun_keeps_old_r6: assert property (@(posedge clk) disable iff (rst)
    (rbf && take && !drain) |=> (ovr && rbf && $stable(rx_byte)));
  p_drain_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (drain && !take) |=> (!rbf && !par && !frm && !ovr));
  p_disabled_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && !rx_en && !drain) |=> $stable(rbf));
endmodule

// File: rtl/sio_irq_combine.sv
module sio_irq_combine #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq import sio_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              txs_taken,
  input  logic              txs_done,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_full,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              tx_flush,
  input  logic              rxs_valid,
  input  logic [BYTE_W-1:0] rxs_byte,
  input  logic              rxs_parity_err,
  input  logic              rxs_frame_err,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ERR_BITS =
    (DATA_W'(1) << ST_PAR) | (DATA_W'(1) << ST_FRM) |
    (DATA_W'(1) << ST_OVR) | (DATA_W'(1) << ST_SUM);

  logic sel_ctrl, sel_errv, sel_mask, sel_txd, sel_rxd, sel_stat;
  assign sel_ctrl = bus_addr == ADDR_W'(A_CTRL);
  assign sel_stat = bus_addr == ADDR_W'(A_STAT);
  assign sel_errv = bus_addr == ADDR_W'(A_ERRV);
  assign sel_mask = bus_addr == ADDR_W'(A_MASK);
  assign sel_txd  = bus_addr == ADDR_W'(A_TXD);
  assign sel_rxd  = bus_addr == ADDR_W'(A_RXD);

  logic [DATA_W-1:0] mask_q, status;
  logic tbe, tsbe, rbf, par, frm, ovr;
  logic [BYTE_W-1:0] rx_byte;

  sio_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_ctrl(bus_wr & sel_ctrl), .ctrl_wdata(bus_wdata[CT_W-1:0]),
    .wr_mask(bus_wr & sel_mask), .mask_wdata(bus_wdata),
    .tx_en(tx_enable), .rx_en(rx_enable), .flush(tx_flush), .mask_q(mask_q)
  );

  sio_tx_flags #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst),
    .wr_txd(bus_wr & sel_txd), .wbyte(bus_wdata[BYTE_W-1:0]),
    .flush(tx_flush), .taken(txs_taken), .done(txs_done),
    .tbe(tbe), .tsbe(tsbe), .tx_byte(tx_byte_o)
  );

  sio_rx_flags #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .rx_en(rx_enable),
    .valid(rxs_valid), .byte_in(rxs_byte),
    .par_in(rxs_parity_err), .frm_in(rxs_frame_err),
    .drain(bus_rd & sel_rxd),
    .err_clr(bus_wr & sel_errv & (bus_wdata == '0)),
    .rbf(rbf), .par(par), .frm(frm), .ovr(ovr), .rx_byte(rx_byte)
  );

  always_comb begin
    status          = '0;
    status[ST_TBE]  = tbe;
    status[ST_TSBE] = tsbe;
    status[ST_RBF]  = rbf;
    status[ST_PAR]  = par;
    status[ST_FRM]  = frm;
    status[ST_OVR]  = ovr;
    status[ST_SUM]  = par | frm | ovr;
  end

  assign tx_full = ~tbe;

  sio_irq_combine #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .status(status), .mask(mask_q), .irq(irq)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[CT_TXEN] = tx_enable;
      rd_mux[CT_RXEN] = rx_enable;
    end
    if (sel_stat) rd_mux = status;
    if (sel_errv) rd_mux = status & ERR_BITS;
    if (sel_mask) rd_mux = mask_q;
    if (sel_txd)  rd_mux = DATA_W'(tx_byte_o);
    if (sel_rxd)  rd_mux = DATA_W'(rx_byte);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/sio_status_irq_tb.sv
module sio_status_irq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic txs_taken = 0, txs_done = 0;
  logic [7:0] tx_byte_o;
  logic tx_full, tx_enable, rx_enable, tx_flush;
  logic rxs_valid = 0, rxs_parity_err = 0, rxs_frame_err = 0;
  logic [7:0] rxs_byte = '0;
  logic irq;

  int total = 0, fails = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];
  logic mon_take = 0;

  always #10 clk = ~clk;

  sio_status_irq u_dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
    tick();
    bus_wr = 0;
  endtask

  // driver: queue the expected read data, then issue the read
  task automatic rd(int a, int exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = 3'(a);
    tick();
    bus_rd = 0;
  endtask

  task automatic rx(int b, bit p, bit f);
    rxs_valid = 1; rxs_byte = 8'(b); rxs_parity_err = p; rxs_frame_err = f;
    tick();
    rxs_valid = 0; rxs_parity_err = 0; rxs_frame_err = 0;
  endtask

  // monitor: compare read data in the cycle after a read
  always @(posedge clk) mon_take <= bus_rd;
  always @(negedge clk) begin
    if (mon_take) begin
      if (exp_q.size() == 0) check("monitor queue empty", 1, 0);
      else check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 tx_enable", tx_enable, 0);
    check("R1 rx_enable", rx_enable, 0);
    check("R1 tx_flush", tx_flush, 0);
    rd(1, 'h0003, "R1 status");
    rd(0, 'h0000, "R1 ctrl");
    rd(3, 'h0000, "R1 mask");
    rd(2, 'h0000, "R1 errview");
    // R2 enables
    wr(0, 'h0003);
    check("R2 tx_enable", tx_enable, 1);
    check("R2 rx_enable", rx_enable, 1);
    rd(0, 'h0003, "R2 ctrl readback");
    // R3 transmit flags
    wr(4, 'h005A);
    check("R3 tx_byte", tx_byte_o, 'h5A);
    check("R3 tx_full", tx_full, 1);
    rd(1, 'h0002, "R3 loaded");
    txs_taken = 1; tick(); txs_taken = 0;
    rd(1, 'h0001, "R3 shifting not complete");
    txs_done = 1; tick(); txs_done = 0;
    rd(1, 'h0003, "R3 complete");
    rd(4, 'h005A, "R3 txdata readback");
    // R2 flush
    wr(4, 'h0033);
    rd(1, 'h0002, "R2 before flush");
    wr(0, 'h0007);
    check("R2 flush pulse", tx_flush, 1);
    tick();
    check("R2 flush one cycle", tx_flush, 0);
    rd(1, 'h0003, "R2 flush empties");
    rd(0, 'h0003, "R2 flush bit reads 0");
    // R4 / R8 receive
    rx('hA5, 0, 0);
    rd(1, 'h0007, "R4 rx full");
    rd(5, 'h00A5, "R4 R8 rx byte");
    rd(1, 'h0003, "R8 drained");
    wr(0, 'h0001);
    rx('h11, 0, 0);
    rd(1, 'h0003, "R4 ignored while disabled");
    wr(0, 'h0003);
    // R5 R7 R9 errors
    rx('h3C, 1, 0);
    rd(1, 'h004F, "R5 R7 parity");
    rd(2, 'h0048, "R9 errview parity");
    rd(5, 'h003C, "R8 parity byte");
    rd(1, 'h0003, "R8 parity cleared");
    rx('h77, 0, 1);
    rd(1, 'h0057, "R5 R7 framing");
    rd(2, 'h0050, "R9 errview framing");
    // R6 overrun
    rx('h99, 0, 0);
    rd(1, 'h0077, "R6 overrun flag");
    rd(2, 'h0070, "R9 errview overrun");
    wr(2, 'h0004);
    rd(2, 'h0070, "R9 nonzero write ignored");
    wr(2, 'h0000);
    rd(2, 'h0000, "R9 zero write clears");
    rd(1, 'h0007, "R9 rx full kept");
    rd(5, 'h0077, "R6 old byte kept");
    rd(1, 'h0003, "R8 cleared");
    // R10 mask
    wr(3, 'hFFFF);
    rd(3, 'h0047, "R10 mask bits");
    // R11 irq
    wr(3, 'h0004);
    tick();
    check("R11 masked idle", irq, 0);
    rx('h10, 0, 0);
    check("R11 delay", irq, 0);
    tick();
    check("R11 rx full irq", irq, 1);
    rd(5, 'h0010, "R11 drain byte");
    check("R11 fall delay", irq, 1);
    tick();
    check("R11 fall", irq, 0);
    wr(3, 'h0040);
    rx('h20, 1, 0);
    tick();
    check("R11 R7 sum irq", irq, 1);
    rd(5, 'h0020, "R8 sum byte");
    tick();
    check("R11 sum cleared", irq, 0);
    wr(3, 'h0001);
    tick();
    check("R11 tbe irq", irq, 1);
    wr(4, 'h0042);
    tick();
    check("R11 tbe cleared", irq, 0);
    wr(3, 'h0002);
    tick();
    check("R11 tsbe irq", irq, 1);
    txs_taken = 1; tick(); txs_taken = 0;
    tick();
    check("R11 tsbe cleared", irq, 0);
    tick();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule